// File: doc/BRIEF.md
# Nonvolatile Transfer Sequencer

This block orders the movement of data between a volatile memory array and the nonvolatile cells that shadow it. It accepts store and recall pulses from a command detector, and a supply-good level from a power monitor. A store first erases the old nonvolatile image and then programs the new one. A recall first clears the volatile array and then transfers the nonvolatile image into it. Each phase is shown on its own active-high strobe, and each phase lasts for a parameterised number of clock cycles.

While any transfer runs, the active-low busy output is held low and the access-disable output is held high, so the array interface locks out reads and writes. Whenever the supply is not good, a power-up recall request is latched. Reset also sets this request. The latched recall starts by itself on the first cycle in which the supply is good. The store, the command recall and the power-up recall each have their own phase lengths. The store and recall inputs are plain single-cycle pulses, not a stream, so there is no back-pressure. A pulse that arrives when it cannot be served is lost.

Top module: `nvs_xfer_seq`

## Requirements
- R1: While reset is asserted, busy_n is 0, access_off is 1 and all four phase strobes are 0. Reset sets the power-up recall request.
- R2: A store pulse sampled while idle, with supply_ok high, starts a store. On the next cycle erase_on is high for ST_ERASE cycles. Then prog_on is high for ST_PROG cycles. No programming cycle comes before an erase cycle.
- R3: A recall pulse sampled while idle, with supply_ok high, starts a recall. On the next cycle clear_on is high for RC_CLEAR cycles. Then xfer_on is high for RC_XFER cycles.
- R4: A power-up recall drives clear_on for PU_CLEAR cycles and then xfer_on for PU_XFER cycles.
- R5: Neither kind of recall ever asserts erase_on or prog_on, so recalls leave the nonvolatile cells untouched.
- R6: busy_n stays 0 and access_off stays 1 from the first phase cycle to the last phase cycle. Both release in the cycle after the last second-phase cycle.
- R7: At most one of erase_on, prog_on, clear_on and xfer_on is high in any cycle.
- R8: A store or recall pulse is dropped, not queued, in three cases: while an operation is running, while supply_ok is low, or while a power-up recall is pending.
- R9: While supply_ok is low, no phase strobe is asserted and busy_n is 0. On the first cycle with supply_ok high, a power-up recall starts.
- R10: If supply_ok falls during an operation, all strobes drop on the next cycle. The power-up recall request is then latched again, and that recall runs once the supply recovers.
- R11: When store and recall pulses arrive in the same cycle, the recall wins. A pending power-up recall takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | 1 when the supply is above the switch threshold |
| cmd_store | input | 1 | Single-cycle store request |
| cmd_recall | input | 1 | Single-cycle recall request |
| busy_n | output | 1 | Active-low busy / handshake |
| access_off | output | 1 | Disables array reads and writes |
| erase_on | output | 1 | Store phase 1: erase nonvolatile image |
| prog_on | output | 1 | Store phase 2: program nonvolatile image |
| clear_on | output | 1 | Recall phase 1: clear volatile array |
| xfer_on | output | 1 | Recall phase 2: copy nonvolatile into volatile |

## Verification
The sequencer is driven with five kinds of stimulus:
- Lone store pulses and lone recall pulses. These separate the two phase orders and the two sets of lengths.
- Reset release, and a supply dip while idle. These show that the power-up lengths are used rather than the command-recall lengths.
- A recall pulse injected partway through a store, and pulses sent while the supply is low. These show that requests are dropped and not queued.
- A supply dip in the middle of a store. This shows both that the operation is abandoned and that the power-up recall is re-latched.
- Simultaneous store and recall pulses. These expose the priority order.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
  typedef enum logic [1:0] {OP_STORE, OP_RECALL, OP_PWRUP} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} ph_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvs_pu_latch.sv
`timescale 1ns/1ps
module nvs_pu_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= 1'b1;
    else if (!supply_ok) pend <= 1'b1;
    else if (take)       pend <= 1'b0;
  end

  assert_low_latches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> pend);
  assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && supply_ok) |=> !pend);
endmodule

// File: rtl/nvs_phase_timer.sv
`timescale 1ns/1ps
module nvs_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == ($past(len) - W'(1))));
  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == ($past(cnt) - W'(1))));
endmodule

// File: rtl/nvs_ctrl.sv
`timescale 1ns/1ps
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int W         = 4,
  parameter int ST_ERASE  = 4,
  parameter int ST_PROG   = 6,
  parameter int RC_CLEAR  = 3,
  parameter int RC_XFER   = 5,
  parameter int PU_CLEAR  = 2,
  parameter int PU_XFER   = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         pend,
  input  logic         cmd_store,
  input  logic         cmd_recall,
  input  logic         t_done,
  output logic         take,
  output logic         t_load,
  output logic [W-1:0] t_len,
  output ph_e          ph,
  output op_e          op
);
  ph_e ph_n;
  op_e op_n;

  function automatic logic [W-1:0] first_len(input op_e o);
    case (o)
      OP_STORE:  return W'(ST_ERASE);
      OP_RECALL: return W'(RC_CLEAR);
      default:   return W'(PU_CLEAR);
    endcase
  endfunction

  function automatic logic [W-1:0] second_len(input op_e o);
    case (o)
      OP_STORE:  return W'(ST_PROG);
      OP_RECALL: return W'(RC_XFER);
      default:   return W'(PU_XFER);
    endcase
  endfunction

  always_comb begin
    ph_n   = ph;
    op_n   = op;
    take   = 1'b0;
    t_load = 1'b0;
    t_len  = '0;
    case (ph)
      PH_IDLE: begin
        if (supply_ok && (pend || cmd_recall || cmd_store)) begin
          if (pend) begin
            op_n = OP_PWRUP;
            take = 1'b1;
          end else if (cmd_recall) begin
            op_n = OP_RECALL;
          end else begin
            op_n = OP_STORE;
          end
          ph_n   = PH_FIRST;
          t_load = 1'b1;
          t_len  = first_len(op_n);
        end
      end
      PH_FIRST: begin
        if (!supply_ok) begin
          ph_n = PH_IDLE;
        end else if (t_done) begin
          ph_n   = PH_SECOND;
          t_load = 1'b1;
          t_len  = second_len(op);
        end
      end
      default: begin
        if (!supply_ok || t_done) ph_n = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
      op <= OP_STORE;
    end else begin
      ph <= ph_n;
      op <= op_n;
    end
  end

  assert_op_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |=> (op == $past(op)));
  assert_recall_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && supply_ok && !pend && cmd_recall) |=> (op == OP_RECALL));
  assert_pend_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && supply_ok && pend) |=> (ph == PH_FIRST && op == OP_PWRUP));
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (ph == PH_IDLE));
endmodule

// File: rtl/nvs_xfer_seq.sv
`timescale 1ns/1ps
module nvs_xfer_seq
  import nvs_pkg::*;
#(
  parameter int ST_ERASE = 4,
  parameter int ST_PROG  = 6,
  parameter int RC_CLEAR = 3,
  parameter int RC_XFER  = 5,
  parameter int PU_CLEAR = 2,
  parameter int PU_XFER  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic cmd_store,
  input  logic cmd_recall,
  output logic busy_n,
  output logic access_off,
  output logic erase_on,
  output logic prog_on,
  output logic clear_on,
  output logic xfer_on
);
  localparam int MAXL = max_of(max_of(max_of(ST_ERASE, ST_PROG), max_of(RC_CLEAR, RC_XFER)),
                               max_of(PU_CLEAR, PU_XFER));
  localparam int W = $clog2(MAXL + 1);

  logic         pend, take, t_load, t_done;
  logic [W-1:0] t_len;
  ph_e          ph;
  op_e          op;

  nvs_pu_latch u_pend (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .take(take), .pend(pend)
  );

  nvs_phase_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .done(t_done)
  );

  nvs_ctrl #(
    .W(W), .ST_ERASE(ST_ERASE), .ST_PROG(ST_PROG), .RC_CLEAR(RC_CLEAR),
    .RC_XFER(RC_XFER), .PU_CLEAR(PU_CLEAR), .PU_XFER(PU_XFER)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pend(pend),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall), .t_done(t_done),
    .take(take), .t_load(t_load), .t_len(t_len), .ph(ph), .op(op)
  );

  assign erase_on   = (ph == PH_FIRST)  && (op == OP_STORE);
  assign prog_on    = (ph == PH_SECOND) && (op == OP_STORE);
  assign clear_on   = (ph == PH_FIRST)  && (op != OP_STORE);
  assign xfer_on    = (ph == PH_SECOND) && (op != OP_STORE);
  assign access_off = (ph != PH_IDLE) || pend;
  assign busy_n     = !access_off;

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_on, prog_on, clear_on, xfer_on}));
  assert_erase_before_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_on) |-> $past(erase_on));
  assert_clear_before_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_on) |-> $past(clear_on));
  assert_drop_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !(erase_on || prog_on || clear_on || xfer_on) && !busy_n);
endmodule

// File: tb/test_nvs_xfer_seq.sv
`timescale 1ns/1ps
module test_nvs_xfer_seq;
  localparam int ST_E = 4, ST_P = 6, RC_C = 3, RC_X = 5, PU_C = 2, PU_X = 7;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b1, cmd_store = 1'b0, cmd_recall = 1'b0;
  logic busy_n, access_off, erase_on, prog_on, clear_on, xfer_on;
  int total = 0, fails = 0;

  nvs_xfer_seq #(.ST_ERASE(ST_E), .ST_PROG(ST_P), .RC_CLEAR(RC_C), .RC_XFER(RC_X),
                 .PU_CLEAR(PU_C), .PU_XFER(PU_X)) i_nvs_xfer_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cmd_store(cmd_store),
    .cmd_recall(cmd_recall), .busy_n(busy_n), .access_off(access_off),
    .erase_on(erase_on), .prog_on(prog_on), .clear_on(clear_on), .xfer_on(xfer_on)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int strobes();
    return int'(erase_on) + int'(prog_on) + int'(clear_on) + int'(xfer_on);
  endfunction

  // Counts phase cycles until busy_n releases; optionally pulses recall at index inj.
  task automatic measure(input int inj, output int ne, output int np, output int nc,
                         output int nx, output int ordered, output int multi);
    int seen2 = 0;
    ne = 0; np = 0; nc = 0; nx = 0; ordered = 1; multi = 0;
    for (int i = 0; i < 500; i++) begin
      if (busy_n) break;
      ne += int'(erase_on); np += int'(prog_on);
      nc += int'(clear_on); nx += int'(xfer_on);
      if (strobes() > 1) multi = 1;
      if (prog_on || xfer_on) seen2 = 1;
      if ((erase_on || clear_on) && seen2) ordered = 0;
      if (access_off !== 1'b1) ordered = 0;
      cmd_recall = (i == inj);
      @(negedge clk);
    end
    cmd_recall = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic r);
    cmd_store = s; cmd_recall = r;
    @(negedge clk);
    cmd_store = 1'b0; cmd_recall = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "idle strobes", strobes(), 0);
    end
    chk(req, "idle busy_n", int'(busy_n), 1);
  endtask

  task automatic t_reset_pwrup();
    int ne, np, nc, nx, ord, mul;
    rst_n = 1'b0; supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy_n in reset", int'(busy_n), 0);
    chk("R1", "access_off in reset", int'(access_off), 1);
    chk("R1", "strobes in reset", strobes(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    measure(-1, ne, np, nc, nx, ord, mul);
    chk("R4", "pwrup clear cycles", nc, PU_C);
    chk("R4", "pwrup xfer cycles", nx, PU_X);
    chk("R5", "pwrup erase+prog", ne + np, 0);
    chk("R6", "pwrup order/lockout", ord, 1);
    chk("R7", "pwrup single strobe", mul, 0);
    chk("R6", "busy_n released", int'(busy_n), 1);
  endtask

  task automatic t_store();
    int ne, np, nc, nx, ord, mul;
    quiet("R6", 2);
    pulse(1'b1, 1'b0);
    measure(-1, ne, np, nc, nx, ord, mul);
    chk("R2", "store erase cycles", ne, ST_E);
    chk("R2", "store prog cycles", np, ST_P);
    chk("R2", "store order", ord, 1);
    chk("R2", "store recall strobes", nc + nx, 0);
    chk("R7", "store single strobe", mul, 0);
  endtask

  task automatic t_recall();
    int ne, np, nc, nx, ord, mul;
    quiet("R6", 2);
    pulse(1'b0, 1'b1);
    measure(-1, ne, np, nc, nx, ord, mul);
    chk("R3", "recall clear cycles", nc, RC_C);
    chk("R3", "recall xfer cycles", nx, RC_X);
    chk("R3", "recall order", ord, 1);
    chk("R5", "recall erase+prog", ne + np, 0);
  endtask

  task automatic t_busy_drop();
    int ne, np, nc, nx, ord, mul;
    quiet("R8", 2);
    pulse(1'b1, 1'b0);
    measure(3, ne, np, nc, nx, ord, mul);
    chk("R8", "store erase with recall injected", ne, ST_E);
    chk("R8", "store prog with recall injected", np, ST_P);
    chk("R8", "no recall phase inside store", nc + nx, 0);
    quiet("R8", 8);
  endtask

  task automatic t_supply_idle();
    int ne, np, nc, nx, ord, mul;
    supply_ok = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (i == 2) cmd_store = 1'b1; else cmd_store = 1'b0;
      @(negedge clk);
      chk("R9", "strobes with supply low", strobes(), 0);
      chk("R9", "busy_n with supply low", int'(busy_n), 0);
    end
    cmd_store = 1'b0;
    supply_ok = 1'b1;
    @(negedge clk);
    measure(-1, ne, np, nc, nx, ord, mul);
    chk("R9", "recovery clear cycles", nc, PU_C);
    chk("R9", "recovery xfer cycles", nx, PU_X);
    chk("R8", "store sent while low dropped", ne + np, 0);
    quiet("R8", 6);
  endtask

  task automatic t_abort();
    int ne, np, nc, nx, ord, mul;
    pulse(1'b1, 1'b0);
    chk("R2", "erase starts next cycle", int'(erase_on), 1);
    repeat (2) @(negedge clk);
    supply_ok = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "strobes after drop", strobes(), 0);
      chk("R10", "busy_n after drop", int'(busy_n), 0);
    end
    supply_ok = 1'b1;
    @(negedge clk);
    measure(-1, ne, np, nc, nx, ord, mul);
    chk("R10", "relatched clear cycles", nc, PU_C);
    chk("R10", "relatched xfer cycles", nx, PU_X);
    chk("R10", "store not resumed", ne + np, 0);
  endtask

  task automatic t_prio();
    int ne, np, nc, nx, ord, mul;
    quiet("R11", 2);
    pulse(1'b1, 1'b1);
    measure(-1, ne, np, nc, nx, ord, mul);
    chk("R11", "both: clear cycles", nc, RC_C);
    chk("R11", "both: xfer cycles", nx, RC_X);
    chk("R11", "both: no store", ne + np, 0);
    quiet("R11", 6);
  endtask

  initial begin
    t_reset_pwrup();
    t_store();
    t_recall();
    t_busy_drop();
    t_supply_idle();
    t_abort();
    t_prio();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule